// File: doc/BRIEF.md
# Dual-Mode Parallel Port Expander

This block hangs off an 8-bit processor bus and provides nine 8-bit parallel ports. Each port bit can be an input or an output. For every bit the block keeps an output latch and an output-enable, and it passes pin values through a two-flop synchroniser before the bus reads them. The pads themselves sit outside the block. It has separate `port_in`, `port_out` and `port_oe` vectors. Port k (k = 1..9) occupies bits `[8k-1 : 8(k-1)]` of each vector.

Port direction comes from one of two sources, chosen by a mode pin. In soft mode, three bus-writable control registers set the direction. In hard mode, a 3-bit strap fixes the direction of ports 1 to 6, and ports 7 to 9 stay inputs. Ports 2 and 5 split into two independently controlled nibbles. Port 8 has a direction bit for each of its bits.

The bus has two styles. The strobe style uses separate active-low read and write strobes. The enable style uses a read/write line qualified by an active-high enable. A parameter sets the reset level of the output latches, so a port that comes out of reset as an output drives either all-high or all-low.

Top module: `pio_expander`

## Requirements
- R1: Address k-1 (0..8) reads and writes the data of port k. Address 9 is the group-direction register, address 10 the upper-port direction register and address 11 the port-8 bit-direction register. Reads of addresses 12..15 return 0. `dout` is 0 whenever `dout_oe` is low.
- R2: In soft mode, a 1 in the group-direction register makes the group an output. The bit assignment is: bit0 port 1, bit1 port 2 bits 3..0, bit2 port 2 bits 7..4, bit3 port 3, bit4 port 4, bit5 port 5 bits 3..0, bit6 port 5 bits 7..4, bit7 port 6.
- R3: In soft mode, bit0 of the upper-port register makes port 7 an output and bit1 makes port 9 an output. Bit i of the port-8 register makes port 8 bit i an output.
- R4: In hard mode (`mode_hard`=1), with strap value n, port k for k = 1..6 is an output exactly when k <= n. Ports 7 to 9 are inputs. Writes to the three direction registers are ignored and leave their read-back values unchanged.
- R5: Reset clears all three direction registers, so every port is an input in soft mode. The output latches reset to all ones when `RST_HIGH`=1 and to all zeros when `RST_HIGH`=0. In hard mode, the strap-selected ports drive that level right after reset.
- R6: A port read returns the output latch for output bits. For input bits it returns the pin value, which is visible once the pin has been stable for two clock edges.
- R7: Strobe style (`bus_style`=0): `dout_oe` = !`cs_n` & !`rd_rw`. A write commits at the first clock edge that samples `wr_en` high after it was sampled low, with `cs_n` low at that edge.
- R8: Enable style (`bus_style`=1): `dout_oe` = !`cs_n` & `rd_rw` & `wr_en`. A write commits at the first clock edge that samples `wr_en` low after it was sampled high, with `cs_n` and `rd_rw` both low at that edge.
- R9: `port_out` always shows the output latches and `port_oe` always shows the active direction, bit for bit.
- R10: Strobe edges seen while `cs_n` is high change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_hard | input | 1 | 1 = strap-fixed directions, 0 = register-set directions |
| bus_style | input | 1 | 0 = separate strobes, 1 = read/write line plus enable |
| strap | input | 3 | Hard-mode direction strap |
| cs_n | input | 1 | Active-low chip select |
| rd_rw | input | 1 | Read strobe (active low) or read/write select (1 = read) |
| wr_en | input | 1 | Write strobe (active low) or enable (active high) |
| addr | input | 4 | Register address |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_oe | output | 1 | Drive enable for the data bus |
| port_in | input | 72 | Pin levels of all nine ports |
| port_out | output | 72 | Output latch levels of all nine ports |
| port_oe | output | 72 | Per-bit output enables |

## Verification
The bench builds two copies of the block side by side on the same stimulus, one with `RST_HIGH`=1 and one with `RST_HIGH`=0. Comparing them is what exposes the reset level of the output latches in both soft and hard mode. Both instances keep the default 8-bit data and 4-bit address widths, so the full nibble split of ports 2 and 5 and the complete address decode, including the four unused addresses, are exercised. Random register traffic alternates between the two bus styles, which brings the edge detection of both strobe schemes within reach of the same model.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int NPORT   = 9;
    localparam int NGRP    = 8;
    localparam int A_GRP   = 9;
    localparam int A_UPPER = 10;
    localparam int A_P8    = 11;

    // Hard-mode strap: port k (1..6) is an output when k <= n.
    function automatic logic [NGRP-1:0] strap_groups(input logic [2:0] n);
        logic [NGRP-1:0] g;
        g[0] = (n >= 3'd1);
        g[1] = (n >= 3'd2);
        g[2] = (n >= 3'd2);
        g[3] = (n >= 3'd3);
        g[4] = (n >= 3'd4);
        g[5] = (n >= 3'd5);
        g[6] = (n >= 3'd5);
        g[7] = (n >= 3'd6);
        return g;
    endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pio_bus.sv
module pio_bus (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_style,
    input  logic cs_n,
    input  logic rd_rw,
    input  logic wr_en,
    output logic wr_fire,
    output logic rd_drive
);
    typedef struct packed {
        logic strb;
    } bus_t;

    bus_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.strb = wr_en;
        if (bus_style) begin
            wr_fire  = !cs_n && !rd_rw && st_q.strb && !wr_en;
            rd_drive = !cs_n && rd_rw && wr_en;
        end else begin
            wr_fire  = !cs_n && !st_q.strb && wr_en;
            rd_drive = !cs_n && !rd_rw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_SHOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire ##1 $stable(bus_style) |-> !wr_fire); // R7
    AST_FIRE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> !cs_n); // R10
endmodule

// File: rtl/pio_dir.sv
module pio_dir
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_hard,
    input  logic [2:0]          strap,
    input  logic [DW-1:0]       cr_grp,
    input  logic [DW-1:0]       cr_upper,
    input  logic [DW-1:0]       cr_p8,
    output logic [NPORT*DW-1:0] oe
);
    localparam int HALF = DW / 2;

    logic [NGRP-1:0] grp;
    logic            up7, up9;
    logic [DW-1:0]   bit8;

    always_comb begin
        grp  = mode_hard ? strap_groups(strap) : cr_grp[NGRP-1:0];
        up7  = !mode_hard && cr_upper[0];
        up9  = !mode_hard && cr_upper[1];
        bit8 = mode_hard ? '0 : cr_p8;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        if (p == 0) begin : g_p1
            assign oe[p*DW +: DW] = {DW{grp[0]}};
        end else if (p == 1) begin : g_p2
            assign oe[p*DW +: DW] = {{HALF{grp[2]}}, {HALF{grp[1]}}};
        end else if (p == 2) begin : g_p3
            assign oe[p*DW +: DW] = {DW{grp[3]}};
        end else if (p == 3) begin : g_p4
            assign oe[p*DW +: DW] = {DW{grp[4]}};
        end else if (p == 4) begin : g_p5
            assign oe[p*DW +: DW] = {{HALF{grp[6]}}, {HALF{grp[5]}}};
        end else if (p == 5) begin : g_p6
            assign oe[p*DW +: DW] = {DW{grp[7]}};
        end else if (p == 6) begin : g_p7
            assign oe[p*DW +: DW] = {DW{up7}};
        end else if (p == 7) begin : g_p8
            assign oe[p*DW +: DW] = bit8;
        end else begin : g_p9
            assign oe[p*DW +: DW] = {DW{up9}};
        end
    end

    AST_HARD_UPPER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hard |-> oe[NPORT*DW-1:6*DW] == '0); // R4
    AST_P2_NIBBLE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oe[DW +: HALF]) == 0 || $countones(oe[DW +: HALF]) == HALF); // R2
endmodule

// File: rtl/pio_expander.sv
module pio_expander
    import pio_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 4,
    parameter bit RST_HIGH = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_hard,
    input  logic                bus_style,
    input  logic [2:0]          strap,
    input  logic                cs_n,
    input  logic                rd_rw,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       dout,
    output logic                dout_oe,
    input  logic [NPORT*DW-1:0] port_in,
    output logic [NPORT*DW-1:0] port_out,
    output logic [NPORT*DW-1:0] port_oe
);
    localparam int PW = NPORT * DW;

    typedef struct packed {
        logic [PW-1:0] lat;
        logic [DW-1:0] cr_grp;
        logic [DW-1:0] cr_upper;
        logic [DW-1:0] cr_p8;
    } regs_t;

    regs_t         st_d, st_q;
    logic          wr_fire, rd_drive;
    logic [PW-1:0] pin_s, oe_w, view;
    logic [DW-1:0] rd_data;

    pio_bus u_bus (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
        .rd_rw(rd_rw), .wr_en(wr_en), .wr_fire(wr_fire), .rd_drive(rd_drive)
    );

    pio_sync #(.W(PW)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(port_in), .q(pin_s)
    );

    pio_dir #(.DW(DW)) u_dir (
        .clk(clk), .rst_n(rst_n), .mode_hard(mode_hard), .strap(strap),
        .cr_grp(st_q.cr_grp), .cr_upper(st_q.cr_upper), .cr_p8(st_q.cr_p8),
        .oe(oe_w)
    );

    always_comb begin
        st_d = st_q;
        if (wr_fire) begin
            for (int k = 0; k < NPORT; k++) begin
                if (addr == AW'(k)) st_d.lat[k*DW +: DW] = din;
            end
            if (!mode_hard) begin
                if (addr == AW'(A_GRP))   st_d.cr_grp   = din;
                if (addr == AW'(A_UPPER)) st_d.cr_upper = din;
                if (addr == AW'(A_P8))    st_d.cr_p8    = din;
            end
        end
    end

    always_comb begin
        view    = (oe_w & st_q.lat) | (~oe_w & pin_s);
        rd_data = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (addr == AW'(k)) rd_data = view[k*DW +: DW];
        end
        if (addr == AW'(A_GRP))   rd_data = st_q.cr_grp;
        if (addr == AW'(A_UPPER)) rd_data = st_q.cr_upper;
        if (addr == AW'(A_P8))    rd_data = st_q.cr_p8;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.lat      <= {PW{RST_HIGH}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout     = rd_drive ? rd_data : '0;
    assign dout_oe  = rd_drive;
    assign port_out = st_q.lat;
    assign port_oe  = oe_w;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(port_out)); // R10
    AST_HARD_CR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hard |=> $stable(st_q.cr_grp) && $stable(st_q.cr_p8)); // R4
    AST_DRIVE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !cs_n); // R7
    AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0); // R1
endmodule

// File: tb/pio_expander_tb.sv
module pio_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hard = 1'b0;
    logic        bus_style = 1'b0;
    logic [2:0]  strap = 3'd0;
    logic        cs_n = 1'b1;
    logic        rd_rw = 1'b1;
    logic        wr_en = 1'b1;
    logic [3:0]  addr = 4'd0;
    logic [7:0]  din = 8'd0;
    logic [71:0] port_in = '0;
    logic [7:0]  dout, dout_lo;
    logic        dout_oe, dout_oe_lo;
    logic [71:0] port_out, port_oe, port_out_lo, port_oe_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [71:0] m_lat;
    logic [7:0]  m_cr0, m_cr1, m_cr2;

    always #4 clk = ~clk;

    pio_expander #(.RST_HIGH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_hard(mode_hard), .bus_style(bus_style),
        .strap(strap), .cs_n(cs_n), .rd_rw(rd_rw), .wr_en(wr_en), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe), .port_in(port_in),
        .port_out(port_out), .port_oe(port_oe)
    );

    pio_expander #(.RST_HIGH(1'b0)) u_dut_lo (
        .clk(clk), .rst_n(rst_n), .mode_hard(mode_hard), .bus_style(bus_style),
        .strap(strap), .cs_n(cs_n), .rd_rw(rd_rw), .wr_en(wr_en), .addr(addr),
        .din(din), .dout(dout_lo), .dout_oe(dout_oe_lo), .port_in(port_in),
        .port_out(port_out_lo), .port_oe(port_oe_lo)
    );

    function automatic logic [71:0] f_oe(input logic h, input logic [2:0] n,
                                         input logic [7:0] c0, input logic [7:0] c1,
                                         input logic [7:0] c2);
        logic [71:0] r;
        r = '0;
        for (int p = 0; p < 9; p++) begin
            for (int b = 0; b < 8; b++) begin
                logic v;
                if (h) v = (p < 6) && (p + 1 <= int'(n));
                else begin
                    case (p)
                        0: v = c0[0];
                        1: v = (b < 4) ? c0[1] : c0[2];
                        2: v = c0[3];
                        3: v = c0[4];
                        4: v = (b < 4) ? c0[5] : c0[6];
                        5: v = c0[7];
                        6: v = c1[0];
                        7: v = c2[b];
                        default: v = c1[1];
                    endcase
                end
                r[p*8+b] = v;
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] f_read(input logic [3:0] a, input logic [71:0] oe);
        logic [71:0] vw;
        vw = (oe & m_lat) | (~oe & port_in);
        if (a < 4'd9)  return vw[a*8 +: 8];
        if (a == 4'd9)  return m_cr0;
        if (a == 4'd10) return m_cr1;
        if (a == 4'd11) return m_cr2;
        return 8'd0;
    endfunction

    task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic set_idle(input logic mot);
        @(negedge clk);
        cs_n = 1'b1;
        rd_rw = 1'b1;
        bus_style = mot;
        wr_en = mot ? 1'b0 : 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic h, input logic [2:0] n);
        rst_n = 1'b0;
        mode_hard = h;
        strap = n;
        bus_style = 1'b0;
        cs_n = 1'b1; rd_rw = 1'b1; wr_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_lat = '1; m_cr0 = 8'd0; m_cr1 = 8'd0; m_cr2 = 8'd0;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a < 4'd9) m_lat[a*8 +: 8] = d;
        else if (!mode_hard) begin
            if (a == 4'd9)  m_cr0 = d;
            if (a == 4'd10) m_cr1 = d;
            if (a == 4'd11) m_cr2 = d;
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        addr = a; din = d;
        if (!bus_style) begin
            cs_n = 1'b0; rd_rw = 1'b1; wr_en = 1'b0;
            @(negedge clk);
            wr_en = 1'b1;
            @(negedge clk);
        end else begin
            cs_n = 1'b0; rd_rw = 1'b0; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
            @(negedge clk);
        end
        cs_n = 1'b1; rd_rw = 1'b1;
        model_write(a, d);
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d, output logic oe);
        addr = a; cs_n = 1'b0;
        if (!bus_style) rd_rw = 1'b0;
        else begin rd_rw = 1'b1; wr_en = 1'b1; end
        #1;
        d = dout; oe = dout_oe;
        cs_n = 1'b1; rd_rw = 1'b1;
        if (bus_style) wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        logic       roe;
        void'($urandom(32'd7753));
        do_reset(1'b0, 3'd0);

        // R5: soft-mode reset state
        check("R5 soft reset oe", port_oe, '0);
        check("R5 latch high", port_out, {72{1'b1}});
        check("R5 latch low", port_out_lo, '0);
        // R1: idle bus, direction registers and unused addresses
        check("R1 idle dout", {63'd0, dout_oe, dout}, '0);
        for (int a = 9; a < 16; a++) begin
            bus_read(4'(a), rd, roe);
            check($sformatf("R1 read addr %0d", a), {63'd0, roe, rd}, {63'd0, 1'b1, 8'd0});
        end

        // R2: nibble halves of port 2 and port 5
        bus_write(4'd9, 8'b0000_0010);
        check("R2 p2 low nibble", port_oe, f_oe(1'b0, 3'd0, m_cr0, m_cr1, m_cr2));
        check("R2 p2 low literal", port_oe[15:8], 8'h0F);
        bus_write(4'd9, 8'b0100_0000);
        check("R2 p5 high literal", port_oe[39:32], 8'hF0);
        // R3: upper ports and port-8 bit directions
        bus_write(4'd10, 8'b0000_0010);
        bus_write(4'd11, 8'b1010_0101);
        check("R3 p9 and p8 bits", port_oe[71:48], {8'hFF, 8'hA5, 8'h00});
        // R9/R6: write latch, read back output and input bits of port 8
        bus_write(4'd7, 8'h3C);
        check("R9 port_out p8", port_out[63:56], 8'h3C);
        port_in[63:56] = 8'h5A;
        repeat (2) @(negedge clk);
        bus_read(4'd7, rd, roe);
        check("R6 mixed readback", {64'd0, rd}, {64'd0, (8'h3C & 8'hA5) | (8'h5A & 8'h5A)});
        // R10: strobe with chip select high
        addr = 4'd0; din = 8'h00; wr_en = 1'b0;
        @(negedge clk); wr_en = 1'b1; @(negedge clk);
        check("R10 cs high ignored", port_out[7:0], 8'hFF);

        // R8: enable style write and read
        set_idle(1'b1);
        bus_write(4'd2, 8'h81);
        check("R8 enable write", port_out[23:16], 8'h81);
        bus_write(4'd9, 8'b0000_1000);
        bus_read(4'd2, rd, roe);
        check("R8 enable read", {63'd0, roe, rd}, {63'd0, 1'b1, 8'h81});
        // R7: strobe style read needs rd low; enable-style level on rd_rw does nothing
        set_idle(1'b0);
        cs_n = 1'b0; rd_rw = 1'b1; #1;
        check("R7 no drive without rd", {71'd0, dout_oe}, '0);
        cs_n = 1'b1; @(negedge clk);

        // R4: hard-mode strap sweep, direction writes ignored
        mode_hard = 1'b1;
        for (int n = 0; n < 8; n++) begin
            strap = 3'(n);
            @(negedge clk);
            check($sformatf("R4 strap %0d", n), port_oe, f_oe(1'b1, 3'(n), 8'd0, 8'd0, 8'd0));
        end
        bus_write(4'd9, 8'h00);
        bus_write(4'd11, 8'hFF);
        bus_read(4'd9, rd, roe);
        check("R4 cr write ignored", {64'd0, rd}, {64'd0, 8'b0000_1000});
        check("R4 p8 stays input", port_oe[63:56], 8'h00);

        // R6/R9 random soft-mode traffic, both bus styles
        mode_hard = 1'b0;
        for (int i = 0; i < 300; i++) begin
            logic [3:0] a;
            logic [71:0] eo;
            if (($urandom % 8) == 0) set_idle(1'($urandom % 2));
            a = 4'($urandom % 12);
            bus_write(a, 8'($urandom));
            port_in = {8'($urandom), 32'($urandom), 32'($urandom)};
            repeat (2) @(negedge clk);
            eo = f_oe(1'b0, 3'd0, m_cr0, m_cr1, m_cr2);
            check("R9 random oe", port_oe, eo);
            check("R9 random out", port_out, m_lat);
            a = 4'($urandom % 16);
            bus_read(a, rd, roe);
            check($sformatf("R6 random read addr %0d", a), {64'd0, rd}, {64'd0, f_read(a, eo)});
        end

        // R5: hard-mode reset drives parameter level
        do_reset(1'b1, 3'd6);
        check("R5 hard oe", port_oe, {24'd0, {48{1'b1}}});
        check("R5 hard high", port_out[47:0], {48{1'b1}});
        check("R5 hard low", port_out_lo[47:0], '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule